// File: doc/BRIEF.md
# Security-Banked Distributor Control Register Block

This block is the small register file that sits at the very start of an interrupt distributor's address window. It holds three words: a global control register, a read-only type register that describes the configuration, and a read-only implementer identification word. A 32-bit register bus reaches it. Each transfer is a single-cycle request that carries a write flag, a byte offset and a non-secure attribute. Reads return their data one cycle later, marked by a valid strobe. The three group-enable bits of the control register drive outputs that go to the interrupt-routing logic downstream.

The `TWO_SEC` parameter fixes the security model at build time. With two security states, the control register is banked by the attribute of the access. A secure access sees and modifies all three group enables. A non-secure access sees a reduced view and can touch only its own group enable. The affinity-routing enable bits cannot be cleared: they always read as one and ignore writes. With one security state, the attribute has no effect. Every control write raises a write-pending flag for one clock, so software can poll until the update is complete.

Top module: `sec_dist_ctrl`

## Requirements
- R1: After reset, all three group-enable outputs are low, `rvalid` is low and `rdata` is zero. A control read that follows reset returns 0x30 with two security states and 0x10 with one.
- R2: A read of word 2 (byte offset 0x8) returns 0x0000043B in either security mode and for either attribute.
- R3: A read of word 1 (byte offset 0x4) returns (NUM_IRQ-32)/32 in bits [4:0], min(NUM_CPU,8)-1 in bits [7:5], 0xF in bits [22:19] and zero in all other bits.
- R4: With two security states, a secure control read (word 0; address bits [1:0] are ignored) returns write-pending in bit 31, ones in bits 5 and 4, secure group-1 enable in bit 2, non-secure group-1 enable in bit 1 and group-0 enable in bit 0. All other bits are zero.
- R5: With two security states, a non-secure control read returns only write-pending in bit 31, a constant one in bit 4 and the non-secure group-1 enable in bit 1. All other bits read zero.
- R6: With two security states, a secure control write loads bits [2:0] of the write data into the group-0, non-secure group-1 and secure group-1 enables. Bits 5 and 4 stay one whatever value is written.
- R7: With two security states, a non-secure control write changes only the non-secure group-1 enable, from write-data bit 1. The group-0 and secure group-1 enables keep their values.
- R8: With one security state, any control write loads the group-0 enable from bit 0 and the group-1 enable from bit 1, whatever the attribute. Reads show bit 4 as one, the enables in bits 1:0 and write-pending in bit 31. The secure group-1 output stays low.
- R9: The write-pending flag is high during the one clock that follows a control write, and low otherwise. During back-to-back control writes it stays high.
- R10: Reads of any other word offset return zero. Writes to them change no state and do not raise write-pending.
- R11: `rvalid` is high exactly in the cycle after a read request. `rdata` is zero whenever `rvalid` is low.
- R12: The three enable outputs always equal the corresponding stored enable bits, and they change only in the cycle after a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request, one cycle per transfer |
| wr | input | 1 | 1 = write, 0 = read |
| nsec | input | 1 | Access attribute, 1 = non-secure |
| addr | input | ADDR_W | Byte offset; bits [1:0] ignored |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Read data, zero when rvalid is low |
| grp0_en | output | 1 | Group-0 enable |
| grp1ns_en | output | 1 | Non-secure group-1 enable |
| grp1s_en | output | 1 | Secure group-1 enable (always low with one security state) |

## Verification
The hardest state to reach from the ports is the write-pending bit itself. It is only visible to a read placed in the single cycle right after a control write. A read issued a cycle later must see it cleared. During a burst of back-to-back writes it must stay high. The stimulus therefore places reads directly behind writes, issues chains of consecutive control writes, and then reads again after a gap. A second instance built with one security state receives the same secure and non-secure traffic. A reference model steps both instances every clock and compares all outputs.

// File: rtl/sec_dist_ctrl.sv
module sec_dist_ctrl #(
  parameter int TWO_SEC = 1,
  parameter int NUM_IRQ = 128,
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              nsec,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              rvalid,
  output logic [31:0]       rdata,
  output logic              grp0_en,
  output logic              grp1ns_en,
  output logic              grp1s_en
);
  localparam int WIDX = ADDR_W - 2;
  localparam int CPU_SAT = (NUM_CPU > 8) ? 8 : NUM_CPU;
  localparam logic [4:0] LINES = 5'((NUM_IRQ - 32) / 32);
  localparam logic [2:0] CPUS = 3'(CPU_SAT - 1);
  localparam logic [31:0] TYPE_VAL = {9'd0, 4'hF, 11'd0, CPUS, LINES};
  localparam logic [31:0] IID_VAL = 32'h0000_043B;
  localparam logic [WIDX-1:0] IDX_CTL = WIDX'(0);
  localparam logic [WIDX-1:0] IDX_TYPE = WIDX'(1);
  localparam logic [WIDX-1:0] IDX_IID = WIDX'(2);

  logic [WIDX-1:0] widx;
  logic ctl_wr, rd_req, rwp;
  logic g0, g1ns, g1s;
  logic [31:0] ctl_view, rd_mux;

  assign widx   = addr[ADDR_W-1:2];
  assign ctl_wr = req & wr & (widx == IDX_CTL);
  assign rd_req = req & ~wr;

  assign grp0_en   = g0;
  assign grp1ns_en = g1ns;
  assign grp1s_en  = g1s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g0   <= 1'b0;
      g1ns <= 1'b0;
      g1s  <= 1'b0;
      rwp  <= 1'b0;
    end else begin
      rwp <= ctl_wr;
      if (ctl_wr) begin
        if (TWO_SEC != 0) begin
          if (!nsec) {g1s, g1ns, g0} <= wdata[2:0];
          else g1ns <= wdata[1];
        end else begin
          g0   <= wdata[0];
          g1ns <= wdata[1];
        end
      end
    end
  end

  always_comb begin
    if (TWO_SEC != 0 && !nsec)
      ctl_view = {rwp, 25'd0, 1'b1, 1'b1, 1'b0, g1s, g1ns, g0};
    else if (TWO_SEC != 0)
      ctl_view = {rwp, 26'd0, 1'b1, 2'b00, g1ns, 1'b0};
    else
      ctl_view = {rwp, 26'd0, 1'b1, 2'b00, g1ns, g0};
  end

  always_comb begin
    case (widx)
      IDX_CTL:  rd_mux = ctl_view;
      IDX_TYPE: rd_mux = TYPE_VAL;
      IDX_IID:  rd_mux = IID_VAL;
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= 32'd0;
    end else begin
      rvalid <= rd_req;
      rdata  <= rd_req ? rd_mux : 32'd0;
    end
  end

  a_r9_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rwp && !ctl_wr) |=> !rwp);

  a_r12_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({grp0_en, grp1ns_en, grp1s_en}));

  a_r7_ns_write_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (TWO_SEC != 0 && ctl_wr && nsec) |=> ($stable(grp0_en) && $stable(grp1s_en)));

  a_r11_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && !wr));

  a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == 32'd0));

  a_r5_ns_view_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && $past(nsec) && TWO_SEC != 0 && $past(widx == IDX_CTL))
      |-> ((rdata & 32'h7FFF_FFED) == 32'd0));

  a_r8_no_secure_group: assert property (@(posedge clk) disable iff (!rst_n)
    (TWO_SEC == 0) |-> !grp1s_en);
endmodule

// File: tb/test_sec_dist_ctrl.sv
`timescale 1ns/1ps
module test_sec_dist_ctrl;
  localparam int AW = 7;
  localparam int IRQ_A = 128, CPU_A = 4;
  localparam int IRQ_B = 256, CPU_B = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, nsec = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;

  logic rv_a, rv_b, g0_a, g0_b, g1n_a, g1n_b, g1s_a, g1s_b;
  logic [31:0] rd_a, rd_b;

  always #4 clk = ~clk;

  sec_dist_ctrl #(.TWO_SEC(1), .NUM_IRQ(IRQ_A), .NUM_CPU(CPU_A), .ADDR_W(AW)) i_sec_dist_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .nsec(nsec), .addr(addr), .wdata(wdata),
    .rvalid(rv_a), .rdata(rd_a), .grp0_en(g0_a), .grp1ns_en(g1n_a), .grp1s_en(g1s_a));

  sec_dist_ctrl #(.TWO_SEC(0), .NUM_IRQ(IRQ_B), .NUM_CPU(CPU_B), .ADDR_W(AW)) i_sec_dist_ctrl_1s (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .nsec(nsec), .addr(addr), .wdata(wdata),
    .rvalid(rv_b), .rdata(rd_b), .grp0_en(g0_b), .grp1ns_en(g1n_b), .grp1s_en(g1s_b));

  int compared = 0, mismatched = 0;
  string tag = "R1";

  bit m_g0[2], m_g1n[2], m_g1s[2], m_rwp[2], m_rv[2];
  logic [31:0] m_rd[2];

  function automatic logic [31:0] type_word(int irq, int cpu);
    int c;
    c = (cpu > 8) ? 8 : cpu;
    return 32'(((irq - 32) / 32) + ((c - 1) * 32) + (15 * 524288));
  endfunction

  function automatic logic [31:0] ref_read(int m, bit ns, int a);
    int w;
    logic [31:0] v;
    w = a / 4;
    v = 32'd0;
    if (w == 0) begin
      if (m == 0 && !ns)
        v = {m_rwp[m], 31'd0} | 32'h30 | {29'd0, m_g1s[m], m_g1n[m], m_g0[m]};
      else if (m == 0)
        v = {m_rwp[m], 31'd0} | 32'h10 | {30'd0, m_g1n[m], 1'b0};
      else
        v = {m_rwp[m], 31'd0} | 32'h10 | {30'd0, m_g1n[m], m_g0[m]};
    end else if (w == 1) begin
      v = (m == 0) ? type_word(IRQ_A, CPU_A) : type_word(IRQ_B, CPU_B);
    end else if (w == 2) begin
      v = 32'h43B;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        m_g0[m] = 0; m_g1n[m] = 0; m_g1s[m] = 0; m_rwp[m] = 0; m_rv[m] = 0; m_rd[m] = 0;
      end else begin
        bit ctlw;
        ctlw = req && wr && (int'(addr) / 4 == 0);
        m_rv[m] = req && !wr;
        m_rd[m] = (req && !wr) ? ref_read(m, nsec, int'(addr)) : 32'd0;
        if (ctlw) begin
          if (m == 0 && !nsec) begin
            m_g0[m] = wdata[0]; m_g1n[m] = wdata[1]; m_g1s[m] = wdata[2];
          end else if (m == 0) begin
            m_g1n[m] = wdata[1];
          end else begin
            m_g0[m] = wdata[0]; m_g1n[m] = wdata[1];
          end
        end
        m_rwp[m] = ctlw;
      end
    end
  end

  task automatic cmp(int m, logic rv, logic [31:0] rd, logic a0, logic a1, logic a2);
    compared++;
    if (rv !== m_rv[m] || rd !== m_rd[m] || a0 !== m_g0[m] || a1 !== m_g1n[m] || a2 !== m_g1s[m]) begin
      mismatched++;
      $display("FAIL %s inst%0d t=%0t: actual rv=%b rd=%h en=%b%b%b expected rv=%b rd=%h en=%b%b%b",
               tag, m, $time, rv, rd, a2, a1, a0, m_rv[m], m_rd[m], m_g1s[m], m_g1n[m], m_g0[m]);
    end
  endtask

  always @(negedge clk) begin
    cmp(0, rv_a, rd_a, g0_a, g1n_a, g1s_a);
    cmp(1, rv_b, rd_b, g0_b, g1n_b, g1s_b);
  end

  task automatic op(bit w, bit ns, int a, logic [31:0] d);
    req = 1'b1; wr = w; nsec = ns; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tag = "R1";
    gap(3);
    rst_n = 1'b1;
    gap(1);
    op(0, 0, 0, 0); gap(1);
    tag = "R2";
    op(0, 0, 8, 0); op(0, 1, 8, 0); gap(1);
    tag = "R3";
    op(0, 0, 4, 0); op(0, 1, 4, 0); gap(1);
    tag = "R6";
    op(1, 0, 0, 32'hFFFF_FFFF);
    tag = "R9";
    op(0, 0, 0, 0); op(0, 0, 0, 0); gap(1);
    tag = "R4";
    op(0, 0, 3, 0); op(0, 0, 1, 0); gap(1);
    tag = "R5";
    op(0, 1, 0, 0); gap(1);
    tag = "R7";
    op(1, 1, 0, 32'h0); op(0, 0, 0, 0); op(0, 1, 0, 0);
    op(1, 1, 0, 32'hFFFF_FFFF); op(0, 0, 0, 0); gap(1);
    tag = "R6";
    op(1, 0, 0, 32'h0000_0005); op(0, 0, 0, 0); gap(1);
    op(1, 0, 0, 32'hFFFF_FFC8); op(0, 0, 0, 0); gap(1);
    tag = "R8";
    op(1, 1, 0, 32'h0000_0007); op(0, 1, 0, 0); op(0, 0, 0, 0);
    op(1, 0, 0, 32'h0000_0002); op(0, 1, 0, 0); gap(1);
    tag = "R9";
    op(1, 0, 0, 32'h1); op(1, 1, 0, 32'h2); op(1, 0, 0, 32'h4);
    op(0, 0, 0, 0); op(0, 0, 0, 0); op(0, 1, 0, 0); gap(2);
    tag = "R10";
    op(1, 0, 16'h10, 32'hFFFF_FFFF); op(0, 0, 0, 0);
    op(1, 1, 16'h7C, 32'hFFFF_FFFF); op(0, 0, 16'h7C, 0);
    op(0, 0, 16'h10, 0); op(0, 1, 16'h0C, 0); op(0, 0, 16'h40, 0); gap(1);
    tag = "R11";
    op(0, 0, 8, 0); gap(1); op(1, 0, 8, 32'h5); gap(2);
    tag = "R12";
    for (int k = 0; k < 8; k++) begin
      op(1, k[0], 0, 32'(k * 3)); op(0, 0, 0, 0); gap(1);
    end
    tag = "R1";
    rst_n = 1'b0; gap(2); rst_n = 1'b1; gap(1);
    op(0, 0, 0, 0); op(0, 1, 0, 0); gap(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule